// File: doc/BRIEF.md
# Line-Synchronised Decimating Pixel Sampler

The sampler reads an 8-bit status word from an image decoder and turns it into a stream of pixels for one frame of a scanned, fax-style picture. The word carries a dot strobe, a line sync flag and a 4-bit luminance value. The decoder runs off its own clock, so the block passes the strobe, the sync and the luminance through a two-flop synchroniser before it uses any of them.

A start pulse arms a capture with a decimation factor N from 1 to 4. For each line the block waits for a complete sync pulse: sync must go high and then fall low. A fixed guard interval then runs. After it, the block counts dot strobe cycles and keeps the luminance at every Nth rising edge. Each kept sample comes out with its column and row, counting down, and a one-cycle valid strobe. The frame ends after a fixed number of lines with a one-cycle done pulse. An abort input returns the block to idle at any time.

Top module: `line_pixel_sampler`

## Requirements
- R1: In `port_i`, bit 7 is the dot strobe, bit 6 is the line sync and bits 3:0 are the luminance. Bits 5:4 have no effect on any output.
- R2: A `start_i` pulse while idle with `decim_i` in 1..4 starts a capture: `busy_o` goes high and `err_o` is cleared. With `decim_i` 0 or 5..7 the capture does not start, `busy_o` stays low and `err_o` goes high.
- R3: Before each line the block waits for sync high and then sync low. Dot strobes that arrive before that falling edge produce no sample.
- R4: After the sync falling edge is seen, dot strobes are ignored for 10 × `DELAY_CLKS` clock cycles.
- R5: A sample takes N complete dot cycles. Each cycle is a low phase followed by a rising edge. The sample value is the luminance present at the Nth rising edge.
- R6: Each line yields `PIX_PER_LINE` samples (default 160), with `x_o` counting down from `PIX_PER_LINE`-1 to 0. Further strobes before the next sync pulse produce no sample.
- R7: Each frame has `LINES` lines (default 200), with `y_o` counting down from `LINES`-1 to 0. `done_o` pulses for one cycle together with the sample at x=0, y=0, and `busy_o` then drops.
- R8: `abort_i` while busy returns the block to idle on the next edge. `done_o` is not raised, and no further samples appear.
- R9: After reset `busy_o`, `done_o`, `err_o` and `pix_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_i | input | 8 | Decoder status word (asynchronous) |
| decim_i | input | DW (3) | Decimation factor N, sampled at start |
| start_i | input | 1 | Arms a frame capture when idle |
| abort_i | input | 1 | Returns the block to idle |
| busy_o | output | 1 | Capture in progress |
| done_o | output | 1 | One-cycle pulse at the end of the frame |
| err_o | output | 1 | Last start was rejected for an out-of-range N |
| pix_valid_o | output | 1 | One-cycle pulse for each sample |
| pix_o | output | 4 | Sample luminance |
| x_o | output | XW (8) | Column of the sample, counting down |
| y_o | output | YW (8) | Row of the sample, counting down |

## Verification
The hardest case to reach from the ports is a dot strobe that arrives inside the guard window just after sync falls. A correct block ignores it, so the only visible sign of a fault is a shifted sample sequence or an early sample count. For every line the stimulus therefore sends two short strobes right after sync drops, then waits past the guard before sending the real strobes. It also sends strobes before sync rises, while sync is high and after the line quota is full. The bench checks the sample count at the end of each line and every sample value against luminance values it stored for the Nth edges. Frames run with every legal N and with random strobe phase lengths. The unused bits 5:4 carry random values throughout.

// File: rtl/fax_sampler_pkg.sv
package fax_sampler_pkg;
  localparam int DOT_BIT  = 7;
  localparam int SYNC_BIT = 6;
  localparam int LUM_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC_HI,
    ST_SYNC_LO,
    ST_GUARD,
    ST_DOT_LO,
    ST_DOT_HI
  } cap_state_e;
endpackage

// File: rtl/sampler_sync.sv
module sampler_sync #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int CW = $clog2(CYCLES) + 1;

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(CYCLES - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/line_pixel_sampler.sv
module line_pixel_sampler
  import fax_sampler_pkg::*;
#(
  parameter int PIX_PER_LINE = 160,
  parameter int LINES        = 200,
  parameter int GUARD_UNITS  = 10,
  parameter int DELAY_CLKS   = 4,
  parameter int DEC_MAX      = 4,
  localparam int XW = $clog2(PIX_PER_LINE),
  localparam int YW = $clog2(LINES),
  localparam int DW = $clog2(DEC_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       port_i,
  input  logic [DW-1:0]    decim_i,
  input  logic             start_i,
  input  logic             abort_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             pix_valid_o,
  output logic [LUM_W-1:0] pix_o,
  output logic [XW-1:0]    x_o,
  output logic [YW-1:0]    y_o
);
  localparam int GUARD_CYC = GUARD_UNITS * DELAY_CLKS;

  logic [LUM_W+1:0] sync_d, sync_q;
  logic             dot_s, sync_s;
  logic [LUM_W-1:0] lum_s;
  logic             unused_bits;

  assign sync_d      = {port_i[DOT_BIT], port_i[SYNC_BIT], port_i[LUM_W-1:0]};
  assign unused_bits = ^port_i[5:4];

  sampler_sync #(.W(LUM_W + 2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign dot_s  = sync_q[LUM_W+1];
  assign sync_s = sync_q[LUM_W];
  assign lum_s  = sync_q[LUM_W-1:0];

  cap_state_e    state_q;
  logic [DW-1:0] dec_q, cnt_q;
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic          guard_start, guard_done, decim_ok;

  assign guard_start = (state_q == ST_SYNC_LO) && !sync_s;
  assign decim_ok    = (decim_i != '0) && (int'(decim_i) <= DEC_MAX);
  assign busy_o      = (state_q != ST_IDLE);

  guard_timer #(.CYCLES(GUARD_CYC)) u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (guard_start),
    .expired_o(guard_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      dec_q       <= DW'(1);
      cnt_q       <= '0;
      x_q         <= '0;
      y_q         <= '0;
      err_o       <= 1'b0;
      done_o      <= 1'b0;
      pix_valid_o <= 1'b0;
      pix_o       <= '0;
      x_o         <= '0;
      y_o         <= '0;
    end else begin
      pix_valid_o <= 1'b0;
      done_o      <= 1'b0;
      if (abort_i && busy_o) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_i) begin
            if (decim_ok) begin
              dec_q   <= decim_i;
              err_o   <= 1'b0;
              x_q     <= XW'(PIX_PER_LINE - 1);
              y_q     <= YW'(LINES - 1);
              state_q <= ST_SYNC_HI;
            end else begin
              err_o <= 1'b1;
            end
          end
          ST_SYNC_HI: if (sync_s)  state_q <= ST_SYNC_LO;
          ST_SYNC_LO: if (!sync_s) state_q <= ST_GUARD;
          ST_GUARD: if (guard_done) begin
            cnt_q   <= '0;
            state_q <= ST_DOT_LO;
          end
          ST_DOT_LO: if (!dot_s) state_q <= ST_DOT_HI;
          ST_DOT_HI: if (dot_s) begin
            if (cnt_q == dec_q - DW'(1)) begin
              pix_valid_o <= 1'b1;
              pix_o       <= lum_s;
              x_o         <= x_q;
              y_o         <= y_q;
              cnt_q       <= '0;
              if (x_q == '0) begin
                x_q <= XW'(PIX_PER_LINE - 1);
                if (y_q == '0) begin
                  done_o  <= 1'b1;
                  state_q <= ST_IDLE;
                end else begin
                  y_q     <= y_q - 1'b1;
                  state_q <= ST_SYNC_HI;
                end
              end else begin
                x_q     <= x_q - 1'b1;
                state_q <= ST_DOT_LO;
              end
            end else begin
              cnt_q   <= cnt_q + 1'b1;
              state_q <= ST_DOT_LO;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R7: done only with the final sample
  p_done_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pix_valid_o && x_o == '0 && y_o == '0));

  // R5: every sample needs a fresh low phase, so samples never come back to back
  p_no_back_to_back_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |=> !pix_valid_o);

  // R8: abort ends the capture without done
  p_abort_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && busy_o) |=> (!busy_o && !done_o && !pix_valid_o));

  // R2: a bad decimation value is refused
  p_bad_decim_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !decim_ok) |=> (err_o && !busy_o));

  // R2: a good decimation value starts the capture
  p_good_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && decim_ok && !abort_i) |=> (busy_o && !err_o));
endmodule

// File: tb/sim_line_pixel_sampler.sv
`timescale 1ns/1ps
module sim_line_pixel_sampler;
  localparam int PIX   = 6;
  localparam int LINES = 3;
  localparam int DLY   = 3;
  localparam int XW    = $clog2(PIX);
  localparam int YW    = $clog2(LINES);
  localparam int TOTAL = PIX * LINES;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dot_b = 1'b0, sync_b = 1'b0;
  logic [1:0]    junk_b = '0;
  logic [3:0]    lum_b = '0;
  logic [7:0]    port;
  logic [2:0]    decim = 3'd1;
  logic          start = 1'b0, abort = 1'b0;
  logic          busy, done, err, pv;
  logic [3:0]    pix;
  logic [XW-1:0] xo;
  logic [YW-1:0] yo;

  int checks = 0, errors = 0;
  int rx_idx = 0, done_cnt = 0;
  int exp_lum [TOTAL];

  assign port = {dot_b, sync_b, junk_b, lum_b};
  always #2 clk = ~clk;

  line_pixel_sampler #(.PIX_PER_LINE(PIX), .LINES(LINES), .DELAY_CLKS(DLY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .port_i(port), .decim_i(decim),
    .start_i(start), .abort_i(abort), .busy_o(busy), .done_o(done),
    .err_o(err), .pix_valid_o(pv), .pix_o(pix), .x_o(xo), .y_o(yo));

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int exp_x(input int idx); return PIX - 1 - (idx % PIX); endfunction
  function automatic int exp_y(input int idx); return LINES - 1 - (idx / PIX); endfunction

  always @(negedge clk) begin
    if (pv) begin
      if (rx_idx < TOTAL) begin
        chk(int'(pix) == exp_lum[rx_idx], "R1 R5 pixel value", int'(pix), exp_lum[rx_idx]);
        chk(int'(xo) == exp_x(rx_idx), "R6 x coordinate", int'(xo), exp_x(rx_idx));
        chk(int'(yo) == exp_y(rx_idx), "R7 y coordinate", int'(yo), exp_y(rx_idx));
      end else begin
        chk(1'b0, "R6 R7 extra sample", rx_idx, TOTAL - 1);
      end
      rx_idx++;
    end
    if (done) begin
      done_cnt++;
      chk(rx_idx == TOTAL, "R7 done with last sample", rx_idx, TOTAL);
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [3:0] v, input int lo, input int hi);
    @(negedge clk);
    dot_b = 1'b0; lum_b = v; junk_b = 2'($urandom);
    wait_clks(lo);
    dot_b = 1'b1; junk_b = 2'($urandom);
    wait_clks(hi);
  endtask

  task automatic rnd_strobe(input logic [3:0] v);
    strobe(v, 3 + int'($urandom % 4), 3 + int'($urandom % 4));
  endtask

  task automatic run_line(input int l, input int n);
    repeat (2) rnd_strobe(4'($urandom));          // before sync: ignored (R3)
    @(negedge clk); dot_b = 1'b0; sync_b = 1'b1;
    rnd_strobe(4'($urandom));                     // during sync high: ignored (R3)
    @(negedge clk); dot_b = 1'b0;
    wait_clks(2);
    sync_b = 1'b0;
    repeat (2) strobe(4'hF, 2, 2);                // inside guard window (R4)
    @(negedge clk); dot_b = 1'b0;
    wait_clks(36);
    chk(rx_idx == l * PIX, "R4 guard strobes ignored", rx_idx, l * PIX);
    for (int k = 1; k <= PIX * n; k++) begin
      logic [3:0] v;
      v = 4'($urandom);
      if (k % n == 0) exp_lum[l * PIX + k / n - 1] = int'(v);
      rnd_strobe(v);
    end
    @(negedge clk); dot_b = 1'b0;
    wait_clks(4);
    repeat (2) rnd_strobe(4'($urandom));          // past quota: ignored (R6)
    @(negedge clk); dot_b = 1'b0;
    wait_clks(4);
    chk(rx_idx == (l + 1) * PIX, "R3 R6 samples per line", rx_idx, (l + 1) * PIX);
  endtask

  task automatic pulse_start(input logic [2:0] n);
    @(negedge clk); decim = n; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_frame(input int n);
    rx_idx = 0; done_cnt = 0;
    pulse_start(3'(n));
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(err == 1'b0, "R2 err cleared", int'(err), 0);
    for (int l = 0; l < LINES; l++) run_line(l, n);
    wait_clks(4);
    chk(done_cnt == 1, "R7 one done pulse", done_cnt, 1);
    chk(busy == 1'b0, "R7 idle after frame", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    wait_clks(3);
    chk(!busy && !done && !err && !pv, "R9 reset outputs", int'({busy, done, err, pv}), 0);
    rst_n = 1'b1;
    wait_clks(2);

    pulse_start(3'd0);
    chk(err == 1'b1, "R2 decim 0 rejected err", int'(err), 1);
    chk(busy == 1'b0, "R2 decim 0 no start", int'(busy), 0);
    pulse_start(3'd5);
    chk(err == 1'b1 && busy == 1'b0, "R2 decim 5 rejected", int'({err, busy}), 2);
    pulse_start(3'd7);
    chk(err == 1'b1 && busy == 1'b0, "R2 decim 7 rejected", int'({err, busy}), 2);

    for (int n = 1; n <= 4; n++) run_frame(n);
    repeat (2) run_frame(1 + int'($urandom % 4));

    // R8: abort in the middle of the second line
    rx_idx = 0; done_cnt = 0;
    pulse_start(3'd2);
    run_line(0, 2);
    exp_lum[PIX] = 0;
    repeat (2) rnd_strobe(4'($urandom));
    @(negedge clk); sync_b = 1'b1; wait_clks(4);
    @(negedge clk); sync_b = 1'b0; wait_clks(36);
    rnd_strobe(4'd9);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk(busy == 1'b0, "R8 idle after abort", int'(busy), 0);
    repeat (8) rnd_strobe(4'($urandom));
    wait_clks(4);
    chk(rx_idx == PIX, "R8 no samples after abort", rx_idx, PIX);
    chk(done_cnt == 0, "R8 no done on abort", done_cnt, 0);

    run_frame(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule